// File: doc/BRIEF.md
# Dual-Clock Receive Packet FIFO

This block is the elastic store between a receive MAC and the system bus. The MAC pushes one byte per cycle of its own receive clock and marks the last byte of each frame with an end-of-frame strobe. The system side pops 32-bit double words in the system clock domain and sees the oldest word at the read port whenever a full word is stored. The store holds 128 bytes. Pointers and a frame counter cross between the two clocks as Gray code.

Two flags steer the system side. A ready flag asks for service once the fill level reaches a programmable threshold, or once at least one whole frame is stored. An active-low low-level flag warns a reader that is in the middle of a burst that the store is close to empty.

A write into a full store is an overflow. By default the block then discards everything it holds and refuses further bytes until software pulses a clear input. A keep mode instead drops only the rejected byte and keeps the stored data. In both modes a sticky status bit records the event, and that bit can drive an interrupt.

Top module: `rx_pkt_fifo`

## Requirements
- R1: Bytes leave in the order they were written. `rdValid` is high while 4 or more bytes are stored. `rdData` carries the oldest byte in bits 7:0 and the next three bytes in the next higher byte lanes. A pop (`rdEn` while `rdValid`) removes those 4 bytes. Up to 128 bytes can be stored and retrieved.
- R2: `rdReady` is high while the number of stored bytes is at least 8 times the 4-bit `thrCode`. It falls once the level drops below that value, unless R3 holds it high.
- R3: A byte written with `wrEop` high ends a frame. Frame lengths are multiples of 4 bytes. `rdReady` stays high from the time a frame is complete in the store until the double word holding its last byte is popped.
- R4: While `rdActive` is high, `aeN` is low whenever fewer than 12 bytes (3 double words) are stored. While `rdActive` is low, `aeN` is high.
- R5: With `keepMode` low, a write while 128 bytes are stored sets `ovfErr`, which stays set until cleared. The block then discards all stored bytes, so `rdValid` and `rdReady` go low.
- R6: While `ovfErr` is set, writes are ignored. A one-cycle `clrErr` pulse clears `ovfErr` and `ovfStatus`, and writes are accepted again.
- R7: Any overflow, in either mode, sets the sticky `ovfStatus`, which only `clrErr` clears. `irq` is high exactly when `ovfStatus` and `intEn` are both high.
- R8: With `keepMode` high, an overflowing byte is dropped and nothing is discarded or locked out. `ovfErr` stays low, and the 128 stored bytes remain readable.
- R9: After reset, `rdValid`, `ovfErr`, `ovfStatus` and `irq` are low, `aeN` is high, and `rdReady` is low for any nonzero threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | MAC-side clock |
| wrRstN | input | 1 | MAC-side asynchronous reset, active low |
| wrEn | input | 1 | Write one byte |
| wrByte | input | 8 | Byte to store |
| wrEop | input | 1 | Marks the byte as the last one of a frame |
| clrErr | input | 1 | One-cycle pulse, clears the overflow error and status |
| keepMode | input | 1 | 1 keeps the stored data on overflow |
| intEn | input | 1 | Lets the overflow status drive `irq` |
| ovfErr | output | 1 | Latched overflow error, writes locked out |
| ovfStatus | output | 1 | Sticky overflow record |
| irq | output | 1 | Interrupt request |
| rdClk | input | 1 | System clock |
| rdRstN | input | 1 | System-side asynchronous reset, active low |
| rdEn | input | 1 | Pop one double word |
| rdActive | input | 1 | A read burst is under way |
| thrCode | input | 4 | Ready threshold in units of 8 bytes |
| rdData | output | 32 | Oldest stored double word |
| rdValid | output | 1 | A full double word is available |
| rdReady | output | 1 | Threshold reached or a whole frame is stored |
| aeN | output | 1 | Low-level warning, active low |

## Verification
The hardest state to reach is a discard followed by a lockout. It takes exactly 128 accepted bytes, with the write side's delayed copy of the read pointer fully caught up. One more byte must then arrive, and the flush handshake has to finish in both clock domains. The bench drains the store and waits for the pointers to cross before it fills, so the 129th write is the only overflow. It then writes bytes that must vanish, waits out the handshake, clears the error, and proves the store works again with fresh data. The threshold check is a full sweep: every code, at every fill level from 0 to 128, and again at every level while the store is drained.

// File: rtl/rxfifo_pkg.sv
`timescale 1ns/1ps
package rxfifo_pkg;
  // strobes handed from control to datapath; wr* fields live in the write
  // clock domain, rd* fields in the read clock domain
  typedef struct packed {
    logic wrPush;
    logic rdPop;
    logic rdFlush;
  } fifoStrobes_t;
endpackage

// File: rtl/rxfifo_gsync.sv
`timescale 1ns/1ps
// Registers a binary count as Gray code in the source domain, passes it
// through two flops in the destination domain and converts it back.
module rxfifo_gsync #(
  parameter int W = 4
) (
  input  logic         srcClk,
  input  logic         srcRstN,
  input  logic [W-1:0] srcBin,
  input  logic         dstClk,
  input  logic         dstRstN,
  output logic [W-1:0] dstBin
);
  logic [W-1:0] srcGray, meta, settled;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) srcGray <= '0;
    else          srcGray <= srcBin ^ (srcBin >> 1);
  end

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      meta    <= '0;
      settled <= '0;
    end else begin
      meta    <= srcGray;
      settled <= meta;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) dstBin[i] = ^(settled >> i);
  end
endmodule

// File: rtl/rxfifo_data.sv
`timescale 1ns/1ps
module rxfifo_data
  import rxfifo_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int THRW     = 4,
  parameter int EOPW     = 8,
  parameter int LANES    = 4,
  parameter int AE_WORDS = 3
) (
  input  logic               wrClk,
  input  logic               wrRstN,
  input  logic [7:0]         wrByte,
  input  logic               wrEop,
  input  logic               rdClk,
  input  logic               rdRstN,
  input  logic [THRW-1:0]    thrCode,
  input  logic               rdActive,
  input  fifoStrobes_t       strobes,
  output logic               wrFull,
  output logic [8*LANES-1:0] rdData,
  output logic               rdValid,
  output logic               rdReady,
  output logic               aeN
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = AW + 1;
  localparam int LW    = $clog2(LANES);
  localparam int WW    = PW - LW;
  localparam int THRSH = AW - THRW;

  logic [8:0]      mem [DEPTH];
  logic [PW-1:0]   wrPtr, wrPtrR, rdPtr, rdPtrW, rdLevel;
  logic [WW-1:0]   rdWord, rdWordW;
  logic [EOPW-1:0] eopCnt, eopR, rdEopCnt;
  logic [LANES-1:0] laneEop;

  // ---------------- write domain ----------------
  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrPtr  <= '0;
      eopCnt <= '0;
    end else if (strobes.wrPush) begin
      wrPtr <= wrPtr + 1'b1;
      if (wrEop) eopCnt <= eopCnt + 1'b1;
    end
  end

  always_ff @(posedge wrClk) begin
    if (strobes.wrPush) mem[wrPtr[AW-1:0]] <= {wrEop, wrByte};
  end

  assign rdPtrW = {rdWordW, {LW{1'b0}}};
  assign wrFull = (wrPtr - rdPtrW) == PW'(DEPTH);

  // ---------------- crossings ----------------
  rxfifo_gsync #(.W(PW)) u_wrPtrSync (
    .srcClk(wrClk), .srcRstN(wrRstN), .srcBin(wrPtr),
    .dstClk(rdClk), .dstRstN(rdRstN), .dstBin(wrPtrR));

  rxfifo_gsync #(.W(EOPW)) u_eopSync (
    .srcClk(wrClk), .srcRstN(wrRstN), .srcBin(eopCnt),
    .dstClk(rdClk), .dstRstN(rdRstN), .dstBin(eopR));

  rxfifo_gsync #(.W(WW)) u_rdWordSync (
    .srcClk(rdClk), .srcRstN(rdRstN), .srcBin(rdWord),
    .dstClk(wrClk), .dstRstN(wrRstN), .dstBin(rdWordW));

  // ---------------- read domain ----------------
  assign rdPtr   = {rdWord, {LW{1'b0}}};
  assign rdLevel = wrPtrR - rdPtr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AW-1:0] idx;
    assign idx            = rdPtr[AW-1:0] + AW'(g);
    assign rdData[8*g +: 8] = mem[idx][7:0];
    assign laneEop[g]     = mem[idx][8];
  end

  assign rdValid = rdLevel >= PW'(LANES);
  assign rdReady = (rdLevel >= (PW'(thrCode) << THRSH)) || (eopR != rdEopCnt);
  assign aeN     = !(rdActive && (rdLevel < PW'(AE_WORDS * LANES)));

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdWord   <= '0;
      rdEopCnt <= '0;
    end else if (strobes.rdFlush) begin
      rdWord   <= wrPtrR[PW-1:LW];
      rdEopCnt <= eopR;
    end else if (strobes.rdPop) begin
      rdWord <= rdWord + 1'b1;
      if (|laneEop) rdEopCnt <= rdEopCnt + 1'b1;
    end
  end
endmodule

// File: rtl/rxfifo_ctrl.sv
`timescale 1ns/1ps
module rxfifo_ctrl
  import rxfifo_pkg::*;
(
  input  logic         wrClk,
  input  logic         wrRstN,
  input  logic         wrEn,
  input  logic         wrFull,
  input  logic         clrErr,
  input  logic         keepMode,
  input  logic         intEn,
  input  logic         rdClk,
  input  logic         rdRstN,
  input  logic         rdEn,
  input  logic         rdValid,
  output fifoStrobes_t strobes,
  output logic         ovfErr,
  output logic         ovfStatus,
  output logic         irq
);
  logic flushReq, ackW, reqR, ackR, canWrite, overflow;

  rxfifo_gsync #(.W(1)) u_reqSync (
    .srcClk(wrClk), .srcRstN(wrRstN), .srcBin(flushReq),
    .dstClk(rdClk), .dstRstN(rdRstN), .dstBin(reqR));

  rxfifo_gsync #(.W(1)) u_ackSync (
    .srcClk(rdClk), .srcRstN(rdRstN), .srcBin(ackR),
    .dstClk(wrClk), .dstRstN(wrRstN), .dstBin(ackW));

  // write domain: block while an error is latched or a flush is in flight
  assign canWrite       = !ovfErr && !flushReq && !ackW;
  assign overflow       = wrEn && canWrite && wrFull;
  assign strobes.wrPush = wrEn && canWrite && !wrFull;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      ovfErr    <= 1'b0;
      ovfStatus <= 1'b0;
      flushReq  <= 1'b0;
    end else begin
      if (clrErr)                     ovfErr <= 1'b0;
      else if (overflow && !keepMode) ovfErr <= 1'b1;

      if (clrErr)        ovfStatus <= 1'b0;
      else if (overflow) ovfStatus <= 1'b1;

      if (overflow && !keepMode) flushReq <= 1'b1;
      else if (ackW)             flushReq <= 1'b0;
    end
  end

  assign irq = ovfStatus && intEn;

  // read domain: follow the request, acknowledge a cycle later
  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) ackR <= 1'b0;
    else         ackR <= reqR;
  end

  assign strobes.rdFlush = reqR;
  assign strobes.rdPop   = rdEn && rdValid && !reqR;
endmodule

// File: rtl/rx_pkt_fifo.sv
`timescale 1ns/1ps
module rx_pkt_fifo
  import rxfifo_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int THRW  = 4,
  parameter int EOPW  = 8
) (
  input  logic            wrClk,
  input  logic            wrRstN,
  input  logic            wrEn,
  input  logic [7:0]      wrByte,
  input  logic            wrEop,
  input  logic            clrErr,
  input  logic            keepMode,
  input  logic            intEn,
  output logic            ovfErr,
  output logic            ovfStatus,
  output logic            irq,
  input  logic            rdClk,
  input  logic            rdRstN,
  input  logic            rdEn,
  input  logic            rdActive,
  input  logic [THRW-1:0] thrCode,
  output logic [31:0]     rdData,
  output logic            rdValid,
  output logic            rdReady,
  output logic            aeN
);
  fifoStrobes_t strobes;
  logic         wrFull;

  rxfifo_ctrl u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrFull(wrFull),
    .clrErr(clrErr), .keepMode(keepMode), .intEn(intEn),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdValid(rdValid),
    .strobes(strobes), .ovfErr(ovfErr), .ovfStatus(ovfStatus), .irq(irq));

  rxfifo_data #(.DEPTH(DEPTH), .THRW(THRW), .EOPW(EOPW), .LANES(4), .AE_WORDS(3)) u_data (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrByte(wrByte), .wrEop(wrEop),
    .rdClk(rdClk), .rdRstN(rdRstN), .thrCode(thrCode), .rdActive(rdActive),
    .strobes(strobes), .wrFull(wrFull), .rdData(rdData), .rdValid(rdValid),
    .rdReady(rdReady), .aeN(aeN));
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
`timescale 1ns/1ps
module rx_pkt_fifo_chk (
  input logic wrClk,
  input logic wrRstN,
  input logic rdClk,
  input logic rdRstN,
  input logic clrErr,
  input logic keepMode,
  input logic intEn,
  input logic ovfErr,
  input logic ovfStatus,
  input logic irq,
  input logic rdActive,
  input logic aeN,
  input logic rdValid,
  input logic rdPop
);
  a_r5_err_latched: assert property (@(posedge wrClk) disable iff (!wrRstN)
    ovfErr && !clrErr |=> ovfErr);

  a_r7_status_sticky: assert property (@(posedge wrClk) disable iff (!wrRstN)
    ovfStatus && !clrErr |=> ovfStatus);

  a_r7_irq_needs_enable: assert property (@(posedge wrClk) disable iff (!wrRstN)
    irq |-> intEn);

  a_r8_keep_no_err: assert property (@(posedge wrClk) disable iff (!wrRstN)
    keepMode && !ovfErr |=> !ovfErr);

  a_r4_ae_idle_high: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rdActive |-> aeN);

  a_r1_pop_needs_word: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdPop |-> rdValid);
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk u_chk (
  .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
  .clrErr(clrErr), .keepMode(keepMode), .intEn(intEn),
  .ovfErr(ovfErr), .ovfStatus(ovfStatus), .irq(irq),
  .rdActive(rdActive), .aeN(aeN), .rdValid(rdValid), .rdPop(strobes.rdPop));

// File: tb/rx_pkt_fifo_test.sv
`timescale 1ns/1ps
module rx_pkt_fifo_test;
  logic wrClk = 0, rdClk = 0, wrRstN = 0, rdRstN = 0;
  logic wrEn = 0, wrEop = 0, clrErr = 0, keepMode = 0, intEn = 0;
  logic rdEn = 0, rdActive = 0;
  logic [7:0] wrByte = 0;
  logic [3:0] thrCode = 4'd1;
  logic ovfErr, ovfStatus, irq, rdValid, rdReady, aeN;
  logic [31:0] rdData;

  int checks = 0, fails = 0;
  int seq = 0;
  bit done = 0;
  logic [7:0] expQ[$];

  rx_pkt_fifo uut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrByte(wrByte), .wrEop(wrEop),
    .clrErr(clrErr), .keepMode(keepMode), .intEn(intEn),
    .ovfErr(ovfErr), .ovfStatus(ovfStatus), .irq(irq),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdActive(rdActive),
    .thrCode(thrCode), .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady), .aeN(aeN));

  always #10 wrClk = ~wrClk;
  initial begin #3; forever #10 rdClk = ~rdClk; end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge rdClk);
    repeat (n) @(negedge wrClk);
  endtask

  // one byte write; 'keep' says whether the model expects it stored
  task automatic wr1(input bit eop, input bit keep);
    @(negedge wrClk);
    wrEn = 1; wrByte = seq[7:0]; wrEop = eop;
    if (keep) expQ.push_back(seq[7:0]);
    seq++;
    @(negedge wrClk);
    wrEn = 0; wrEop = 0;
  endtask

  task automatic pop1(input string tag);
    logic [31:0] exp;
    @(negedge rdClk);
    exp = {expQ[3], expQ[2], expQ[1], expQ[0]};
    chk(tag, rdData, exp);
    rdEn = 1;
    @(negedge rdClk);
    rdEn = 0;
    repeat (4) void'(expQ.pop_front());
  endtask

  task automatic drain(input int thrBytes);
    rdActive = 1;
    while (expQ.size() >= 4) begin
      @(negedge rdClk);
      chk("R4 aeN", aeN, (expQ.size() < 12) ? 0 : 1);
      chk("R2 ready on drain", rdReady, (expQ.size() >= thrBytes) ? 1 : 0);
      chk("R1 valid", rdValid, 1);
      pop1("R1 data");
    end
    @(negedge rdClk);
    chk("R1 empty after drain", rdValid, 0);
    rdActive = 0;
    settle(8);
  endtask

  task automatic clearErr;
    @(negedge wrClk); clrErr = 1;
    @(negedge wrClk); clrErr = 0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge wrClk);
    wrRstN = 1; rdRstN = 1;
    settle(3);
    // R9 reset state
    chk("R9 rdValid", rdValid, 0);
    chk("R9 rdReady", rdReady, 0);
    chk("R9 ovfErr", ovfErr, 0);
    chk("R9 ovfStatus", ovfStatus, 0);
    chk("R9 irq", irq, 0);
    chk("R9 aeN", aeN, 1);

    // R2 sweep: every code, every level 0..128, filling then draining
    for (int t = 0; t < 16; t++) begin
      thrCode = 4'(t);
      for (int k = 0; k <= 128; k++) begin
        settle(4);
        chk("R2 ready on fill", rdReady, (k >= 8 * t) ? 1 : 0);
        if (k < 128) wr1(0, 1);
      end
      drain(8 * t);
    end

    // R3 frames with a high threshold so only frames raise ready
    thrCode = 4'd15;
    for (int i = 0; i < 8; i++) wr1(0, 1);
    settle(6);
    chk("R3 no frame no ready", rdReady, 0);
    drain(120);
    for (int i = 0; i < 8; i++) wr1(i == 7, 1);
    settle(6);
    chk("R3 frame ready", rdReady, 1);
    pop1("R3 data");
    @(negedge rdClk);
    chk("R3 ready before last word", rdReady, 1);
    pop1("R3 data");
    @(negedge rdClk);
    chk("R3 ready after last word", rdReady, 0);
    for (int i = 0; i < 4; i++) wr1(i == 3, 1);
    for (int i = 0; i < 12; i++) wr1(i == 11, 1);
    settle(6);
    pop1("R3 data");
    @(negedge rdClk);
    chk("R3 second frame keeps ready", rdReady, 1);
    pop1("R3 data"); pop1("R3 data");
    @(negedge rdClk);
    chk("R3 ready held to last word", rdReady, 1);
    pop1("R3 data");
    @(negedge rdClk);
    chk("R3 ready gone", rdReady, 0);
    settle(8);

    // R5/R6/R7 overflow with discard
    thrCode = 4'd1; intEn = 1; keepMode = 0;
    for (int i = 0; i < 128; i++) wr1(0, 1);
    chk("R5 no error when full", ovfErr, 0);
    wr1(0, 0);
    chk("R5 error latched", ovfErr, 1);
    chk("R7 status set", ovfStatus, 1);
    chk("R7 irq enabled", irq, 1);
    expQ.delete();
    settle(12);
    chk("R5 discarded valid", rdValid, 0);
    chk("R5 discarded ready", rdReady, 0);
    for (int i = 0; i < 8; i++) wr1(0, 0);
    settle(12);
    chk("R6 locked out valid", rdValid, 0);
    chk("R6 locked out ready", rdReady, 0);
    chk("R5 error holds", ovfErr, 1);
    clearErr();
    chk("R6 error cleared", ovfErr, 0);
    chk("R6 status cleared", ovfStatus, 0);
    chk("R7 irq cleared", irq, 0);
    for (int i = 0; i < 4; i++) wr1(0, 1);
    settle(6);
    chk("R6 accepts again", rdValid, 1);
    pop1("R6 data after clear");
    settle(8);

    // R8 keep mode, R7 interrupt gating
    keepMode = 1; intEn = 0;
    for (int i = 0; i < 128; i++) wr1(0, 1);
    wr1(0, 0);
    chk("R8 no error", ovfErr, 0);
    chk("R7 status in keep mode", ovfStatus, 1);
    chk("R7 irq masked", irq, 0);
    @(negedge wrClk); intEn = 1;
    @(negedge wrClk);
    chk("R7 irq unmasked", irq, 1);
    settle(6);
    drain(8);
    chk("R8 stays clear", ovfErr, 0);
    clearErr();
    chk("R7 status cleared", ovfStatus, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule